// File: doc/BRIEF.md
# Quadword Load Element Formatter

This block sits on the load return path of a processor or DMA engine. It is handed one naturally aligned 64-bit quadword fetched from memory, together with the access address, the access width (1, 2, 4 or 8 bytes) and an endian selector. It returns the addressed element placed in the low bits of a 64-bit result, with zeros above it. When the address is not a multiple of the access width, it raises a misalignment fault instead. Memory byte lane `i` of the quadword (bits `8i+7:8i`) holds the byte whose address has low bits equal to `i`.

The endian selector is a run-time input and is sampled with each request. In little-endian mode the byte at the lowest address becomes the least significant byte of the element. In big-endian mode it becomes the most significant byte. A valid/ready pair on each side carries requests in and results out. A result appears one clock after its request is accepted and is held until the consumer takes it.

Top module: `qlf_top`

## Requirements
- R1: While reset is high and after it is released, `resp_valid` and `resp_fault` are 0, `resp_data` is 0 and `req_ready` is 1.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) makes `resp_valid` high after that edge. Without an acceptance, and with the pending result taken, `resp_valid` is low after the next edge.
- R3: While `resp_valid` is high and `resp_ready` is low, `req_ready` is low, and `resp_data` and `resp_fault` stay unchanged.
- R4: Size code 0 (1 byte) never faults at any offset, and returns lane `addr[2:0]` in bits 7:0.
- R5: Endian input 0 (little): the byte at the lowest address is the least significant byte. With lanes 0..7 holding 0xf0..0xf7, a 2-byte load at offset 0 returns 0xf1f0 and a 4-byte load at offset 4 returns 0xf7f6f5f4.
- R6: Endian input 1 (big): the byte at the lowest address is the most significant byte. With the same quadword, offset 0 with 2 bytes returns 0xf0f1 and offset 4 with 4 bytes returns 0xf4f5f6f7.
- R7: A fault is raised when size code 1 (2 bytes) has `addr[0]`=1, when size code 2 (4 bytes) has `addr[1:0]`≠0, or when size code 3 (8 bytes) has `addr[2:0]`≠0.
- R8: A faulting response has `resp_fault`=1 with `resp_valid`=1 and `resp_data`=0.
- R9: The endian input takes effect per request. Back-to-back requests with different endian values are each formatted by their own value.
- R10: All result bits above the element width are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W (16) | Byte address of the element |
| req_size | input | 2 | Width code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_big_endian | input | 1 | 1 selects big-endian byte order |
| req_quad | input | 64 | Aligned quadword containing the element |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Consumer takes the result this cycle |
| resp_data | output | 64 | Zero-extended element, 0 on fault |
| resp_fault | output | 1 | Misalignment detected |

## Verification
Each result is due exactly one clock edge after its request is accepted. The bench drives requests on the falling edge and samples `resp_*` on the next falling edge, half a cycle after the register loads. During a stall the result must not move for as long as `resp_ready` stays low. The stall scenario therefore samples on every falling edge of the hold window. It then checks that the queued request's result lands on the falling edge after the edge that releases the stall.

// File: rtl/qlf_pkg.sv
package qlf_pkg;
  localparam int unsigned QLF_MAX_BYTES = 8;

  typedef enum logic [1:0] {
    QLF_SZ_1 = 2'd0,
    QLF_SZ_2 = 2'd1,
    QLF_SZ_4 = 2'd2,
    QLF_SZ_8 = 2'd3
  } qlf_size_e;

  // number of bytes minus one for a size code
  function automatic int unsigned qlf_len_m1(input logic [1:0] code);
    return (32'd1 << code) - 32'd1;
  endfunction
endpackage

// File: rtl/qlf_align_check.sv
module qlf_align_check #(
  parameter int unsigned BYTES = 8,
  localparam int unsigned OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0] off,
  input  logic [OFF_W-1:0] len_m1,
  output logic             misaligned
);
  // naturally aligned means the offset bits covered by the width are clear
  always_comb misaligned = |(off & len_m1);
endmodule

// File: rtl/qlf_lane_pick.sv
module qlf_lane_pick #(
  parameter int unsigned BYTES = 8,
  parameter int unsigned LANE  = 0,
  localparam int unsigned OFF_W = $clog2(BYTES)
) (
  input  logic [8*BYTES-1:0] quad,
  input  logic [OFF_W-1:0]   off,
  input  logic [OFF_W-1:0]   len_m1,
  input  logic               big,
  output logic [7:0]         lane_out
);
  localparam logic [OFF_W-1:0] LANE_C = OFF_W'(LANE);

  logic             active;
  logic [OFF_W-1:0] rel;
  logic [OFF_W-1:0] src;

  always_comb begin
    active   = (LANE_C <= len_m1);
    rel      = big ? (len_m1 - LANE_C) : LANE_C;
    src      = off + rel;
    lane_out = active ? quad[8*src +: 8] : 8'h00;
  end
endmodule

// File: rtl/qlf_top.sv
module qlf_top #(
  parameter int unsigned BYTES  = 8,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned OFF_W = $clog2(BYTES),
  localparam int unsigned DW    = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_big_endian,
  input  logic [DW-1:0]     req_quad,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DW-1:0]     resp_data,
  output logic              resp_fault
);
  import qlf_pkg::*;

  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] len_m1;
  logic             misaligned;
  logic [DW-1:0]    formatted;
  logic             accept;

  always_comb begin
    off    = req_addr[OFF_W-1:0];
    len_m1 = OFF_W'(qlf_len_m1(req_size));
    accept = req_valid && req_ready;
  end

  qlf_align_check #(.BYTES(BYTES)) u_align (
    .off        (off),
    .len_m1     (len_m1),
    .misaligned (misaligned)
  );

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    qlf_lane_pick #(.BYTES(BYTES), .LANE(g)) u_pick (
      .quad     (req_quad),
      .off      (off),
      .len_m1   (len_m1),
      .big      (req_big_endian),
      .lane_out (formatted[8*g +: 8])
    );
  end

  // a new request may enter when the output slot is empty or draining now
  assign req_ready = !resp_valid || resp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
      resp_fault <= 1'b0;
    end else if (accept) begin
      resp_valid <= 1'b1;
      resp_fault <= misaligned;
      resp_data  <= misaligned ? '0 : formatted;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  a_r2_resp_follows_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> resp_valid);

  a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
    (!(req_valid && req_ready) && (!resp_valid || resp_ready)) |=> !resp_valid);

  a_r3_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data) && $stable(resp_fault)));

  a_r4_byte_never_faults: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_size == QLF_SZ_1) |=> !resp_fault);

  a_r8_fault_zero_data: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (resp_data == '0));

  a_r10_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_size == QLF_SZ_1) |=> (resp_data[DW-1:8] == '0));
endmodule

// File: tb/qlf_top_tb.sv
module qlf_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_addr;
  logic [1:0]  req_size;
  logic        req_big_endian;
  logic [63:0] req_quad;
  logic        resp_valid;
  logic        resp_ready;
  logic [63:0] resp_data;
  logic        resp_fault;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  localparam logic [63:0] Q_F = 64'hf7f6f5f4f3f2f1f0;

  always #2 clk = ~clk;  // 250 MHz

  qlf_top u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_big_endian(req_big_endian),
    .req_quad(req_quad), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .resp_fault(resp_fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference formatting derived from the requirements
  function automatic logic [63:0] model(input logic [63:0] q, input logic [15:0] a,
                                        input logic [1:0] sz, input logic big,
                                        output logic flt);
    int n = 1 << sz;
    int o = int'(a[2:0]);
    logic [63:0] r = '0;
    flt = (int'(a[2:0]) & (n - 1)) != 0;
    if (flt) return '0;
    for (int k = 0; k < n; k++) begin
      if (big) r[8*(n-1-k) +: 8] = q[8*(o+k) +: 8];
      else     r[8*k +: 8]       = q[8*(o+k) +: 8];
    end
    return r;
  endfunction

  // single request with ready consumer; result sampled one cycle later
  task automatic one_req(input string tag, input logic [63:0] q, input logic [15:0] a,
                         input logic [1:0] sz, input logic big);
    logic flt;
    logic [63:0] exp;
    exp = model(q, a, sz, big, flt);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_big_endian = big; req_quad = q;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 64'(resp_valid), 64'd1);
    chk({tag, " data"},  resp_data, exp);
    chk({tag, " fault"}, 64'(resp_fault), 64'(flt));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", 64'(resp_valid), 64'd0);
    chk("R1 data",  resp_data, 64'd0);
    chk("R1 fault", 64'(resp_fault), 64'd0);
    chk("R1 ready", 64'(req_ready), 64'd1);
  endtask

  task automatic t_bytes();
    for (int o = 0; o < 8; o++) begin
      one_req("R4 byte le", Q_F, 16'h0100 + 16'(o), 2'd0, 1'b0);
      one_req("R4 byte be", 64'h0123456789abcdef, 16'h0208 + 16'(o), 2'd0, 1'b1);
      chk("R10 upper", resp_data >> 8, 64'd0);
    end
  endtask

  task automatic t_little();
    one_req("R5 half0", Q_F, 16'h0000, 2'd1, 1'b0);
    chk("R5 half0 lit", resp_data, 64'h000000000000f1f0);
    one_req("R5 word4", Q_F, 16'h0004, 2'd2, 1'b0);
    chk("R5 word4 lit", resp_data, 64'h00000000f7f6f5f4);
    one_req("R5 quad", Q_F, 16'h0010, 2'd3, 1'b0);
    one_req("R5 half6", Q_F, 16'h0006, 2'd1, 1'b0);
    chk("R10 half upper", resp_data >> 16, 64'd0);
  endtask

  task automatic t_big();
    one_req("R6 half0", Q_F, 16'h0000, 2'd1, 1'b1);
    chk("R6 half0 lit", resp_data, 64'h000000000000f0f1);
    one_req("R6 word4", Q_F, 16'h0004, 2'd2, 1'b1);
    chk("R6 word4 lit", resp_data, 64'h00000000f4f5f6f7);
    one_req("R6 quad", Q_F, 16'h0018, 2'd3, 1'b1);
    chk("R6 quad lit", resp_data, 64'hf0f1f2f3f4f5f6f7);
    one_req("R6 half2", Q_F, 16'h0002, 2'd1, 1'b1);
  endtask

  task automatic t_faults();
    for (int o = 0; o < 8; o++) begin
      one_req("R7 half", Q_F, 16'h0040 + 16'(o), 2'd1, o[0]);
      one_req("R7 word", Q_F, 16'h0040 + 16'(o), 2'd2, o[1]);
      one_req("R7 quad", Q_F, 16'h0040 + 16'(o), 2'd3, 1'b0);
    end
    one_req("R8 word3", Q_F, 16'h0003, 2'd2, 1'b0);
    chk("R8 zero", resp_data, 64'd0);
    chk("R8 flag", 64'(resp_fault), 64'd1);
  endtask

  task automatic t_stall();
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 16'h0004; req_size = 2'd2; req_big_endian = 1'b0; req_quad = Q_F;
    @(negedge clk);
    req_addr = 16'h0000; req_size = 2'd3; req_big_endian = 1'b1;  // queued second request
    for (int i = 0; i < 3; i++) begin
      chk("R3 held valid", 64'(resp_valid), 64'd1);
      chk("R3 held data",  resp_data, 64'h00000000f7f6f5f4);
      chk("R3 ready low",  64'(req_ready), 64'd0);
      @(negedge clk);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 second valid", 64'(resp_valid), 64'd1);
    chk("R2 second data",  resp_data, 64'hf0f1f2f3f4f5f6f7);
    @(negedge clk);
    chk("R2 drained", 64'(resp_valid), 64'd0);
  endtask

  task automatic t_endian_switch();
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0000; req_size = 2'd1; req_big_endian = 1'b0; req_quad = Q_F;
    @(negedge clk);
    chk("R9 first le", resp_data, 64'h000000000000f1f0);
    req_big_endian = 1'b1;
    @(negedge clk);
    chk("R9 second be", resp_data, 64'h000000000000f0f1);
    req_big_endian = 1'b0; req_addr = 16'h0004; req_size = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 third le", resp_data, 64'h00000000f7f6f5f4);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_big_endian = 1'b0; req_quad = '0; resp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 64'(resp_valid), 64'd0);
    rst = 1'b0;
    t_reset();
    t_bytes();
    t_little();
    t_big();
    t_faults();
    t_stall();
    t_endian_switch();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule